// File: doc/BRIEF.md
# Burst-Read Bus Initiator

This block is the reading side of a master on a shared 32-bit multiplexed address/data bus. The local logic hands it a start address, a word count of one to sixteen, and a choice between memory space and I/O space. The block then runs one address phase, turns the shared lines over to the target, and gathers each returned word into a local valid/ready output stream. It ends the transaction by releasing the framing strobe in the last data phase. The block takes no part in bus arbitration and performs no writes.

Backpressure from the local sink is passed straight back to the bus. When the one-word holding register is full and the sink is not taking it, the initiator's ready strobe goes high, and the data phases wait. If no target claims the access within a short window after the address phase, the block abandons the transaction and reports an error on the completion pulse.

Top module: `burst_rd_init`

## Requirements
- R1: After reset, and whenever the block is idle, `req_ready` is high, `bus_cyc_n` and `init_rdy_n` are high, `mux_oe` is low and `rsp_valid` is low.
- R2: In the cycle after a request is accepted (`req_valid` and `req_ready` high at a clock edge), the block drives the address phase. In that phase `bus_cyc_n` is low, `init_rdy_n` is high, `mux_oe` is high, `mux_o` equals the request address, and `cmd_be_n` is 4'b0110 for a memory read (`req_io`=0) or 4'b0010 for an I/O read (`req_io`=1).
- R3: In the cycle after the address phase, `mux_oe` is low. In every cycle where `init_rdy_n` is low, `cmd_be_n` is 4'b0000.
- R4: A word transfers on each clock edge where `init_rdy_n`, `tgt_rdy_n` and `tgt_ack_n` are all low. The value on `mux_i` at that edge appears on `rsp_data` with `rsp_valid` high from the next cycle. Words leave the stream in bus order.
- R5: During the data phases, `bus_cyc_n` is low while more than one word is still to be transferred and high while exactly one remains. `init_rdy_n` stays low in the final phase until that word transfers, unless the sink stalls.
- R6: While `rsp_valid` is high and `rsp_ready` is low, `init_rdy_n` is high. During a data phase it is otherwise low. No word is lost or duplicated.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_last` hold their values into the next cycle.
- R8: `rsp_last` is high on the final word of the burst and low on all the others.
- R9: In the cycle after the final word transfers, `done_o` is high for exactly one cycle with `err_o` low. In that cycle `bus_cyc_n` and `init_rdy_n` are high. The block is idle in the cycle after.
- R10: If `tgt_ack_n` is high at each of the first 4 clock edges after the address phase, the next cycle has `done_o` and `err_o` high, no word is delivered, and `bus_cyc_n` and `init_rdy_n` are high. A claim at the 4th edge or earlier keeps the transaction running.
- R11: `req_len_m1` gives the word count minus one, so every length from 1 to 16 words is carried out with exactly that number of transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and accepting a request |
| req_addr | input | 32 | Start address |
| req_len_m1 | input | 4 | Word count minus one |
| req_io | input | 1 | 1 selects I/O space, 0 memory space |
| rsp_valid | output | 1 | Holding register has a word |
| rsp_ready | input | 1 | Local sink accepts the word |
| rsp_data | output | 32 | Returned word |
| rsp_last | output | 1 | Word is the last of the burst |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | With done_o: no target claimed the access |
| mux_o | output | 32 | Address driven onto the shared lines |
| mux_oe | output | 1 | Drive enable for mux_o |
| mux_i | input | 32 | Shared lines as seen from the bus |
| cmd_be_n | output | 4 | Command in the address phase, byte enables (active low) after it |
| bus_cyc_n | output | 1 | Active-low transaction framing strobe |
| init_rdy_n | output | 1 | Active-low initiator ready |
| tgt_rdy_n | input | 1 | Active-low target ready |
| tgt_ack_n | input | 1 | Active-low target claim of the access |

## Verification
The bound assertions check on every cycle the rules that hold locally: the stall rule between a full, unserved holding register and the initiator's ready strobe, and the stability of a stalled output word. They also check that the address drive lasts a single cycle, that byte enables are all active while the initiator is ready, and that the idle bus is quiet and the completion pulse is one cycle long. The bench scenarios are the only place where data order and content, `rsp_last` placement, framing release on the final phase against the remaining count, the exact cycle of completion, and the claim window edge (claim at clock 4 against no claim by clock 4) can be seen. The scenarios sweep every burst length through combinations of target wait states, local backpressure and claim delay.

// File: rtl/burst_rd_init.sv
module burst_rd_init #(
  parameter int W        = 32,
  parameter int MAXW     = 16,
  parameter int SEL_WAIT = 4,
  localparam int LW      = $clog2(MAXW),
  localparam int WDW     = $clog2(SEL_WAIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [W-1:0]  req_addr,
  input  logic [LW-1:0] req_len_m1,
  input  logic          req_io,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [W-1:0]  rsp_data,
  output logic          rsp_last,
  output logic          done_o,
  output logic          err_o,
  output logic [W-1:0]  mux_o,
  output logic          mux_oe,
  input  logic [W-1:0]  mux_i,
  output logic [3:0]    cmd_be_n,
  output logic          bus_cyc_n,
  output logic          init_rdy_n,
  input  logic          tgt_rdy_n,
  input  logic          tgt_ack_n
);
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_IO_RD  = 4'b0010;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_END} st_t;
  st_t st;

  logic [W-1:0]   addr_q;
  logic [LW-1:0]  rem_q;
  logic           io_q;
  logic           seen_q;
  logic [WDW-1:0] wd_q;
  logic           err_q;
  logic           hold_v;
  logic           hold_last;
  logic [W-1:0]   hold_d;

  wire in_data = (st == S_DATA);
  wire last_ph = (rem_q == '0);

  assign init_rdy_n = !(in_data && (!hold_v || rsp_ready));
  wire beat    = !init_rdy_n && !tgt_rdy_n && !tgt_ack_n;
  wire timeout = in_data && !seen_q && tgt_ack_n && (wd_q == WDW'(SEL_WAIT - 1));

  assign req_ready = (st == S_IDLE);
  assign bus_cyc_n = !((st == S_ADDR) || (in_data && !last_ph));
  assign mux_oe    = (st == S_ADDR);
  assign mux_o     = mux_oe ? addr_q : '0;
  assign cmd_be_n  = (st == S_ADDR) ? (io_q ? CMD_IO_RD : CMD_MEM_RD) :
                     in_data        ? 4'b0000 : 4'b1111;
  assign rsp_valid = hold_v;
  assign rsp_data  = hold_d;
  assign rsp_last  = hold_last;
  assign done_o    = (st == S_END);
  assign err_o     = done_o && err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      io_q   <= 1'b0;
      seen_q <= 1'b0;
      wd_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          rem_q  <= req_len_m1;
          io_q   <= req_io;
          seen_q <= 1'b0;
          wd_q   <= '0;
          err_q  <= 1'b0;
          st     <= S_ADDR;
        end
        S_ADDR: st <= S_DATA;
        S_DATA: begin
          if (!tgt_ack_n) seen_q <= 1'b1;
          else if (!seen_q) wd_q <= wd_q + 1'b1;
          if (beat) begin
            if (last_ph) st <= S_END;
            else rem_q <= rem_q - 1'b1;
          end else if (timeout) begin
            err_q <= 1'b1;
            st    <= S_END;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_last <= 1'b0;
      hold_d    <= '0;
    end else if (beat) begin
      hold_v    <= 1'b1;
      hold_last <= last_ph;
      hold_d    <= mux_i;
    end else if (rsp_ready) begin
      hold_v <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_rd_init_chk.sv
module burst_rd_init_chk #(
  parameter int W  = 32,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [W-1:0]  req_addr,
  input logic [LW-1:0] req_len_m1,
  input logic          req_io,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [W-1:0]  rsp_data,
  input logic          rsp_last,
  input logic          done_o,
  input logic          err_o,
  input logic [W-1:0]  mux_o,
  input logic          mux_oe,
  input logic [W-1:0]  mux_i,
  input logic [3:0]    cmd_be_n,
  input logic          bus_cyc_n,
  input logic          init_rdy_n,
  input logic          tgt_rdy_n,
  input logic          tgt_ack_n
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cyc_n && init_rdy_n && !mux_oe));
  // R2
  addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mux_oe |-> (!bus_cyc_n && init_rdy_n));
  // R3
  addr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mux_oe |=> !mux_oe);
  // R3
  be_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_rdy_n |-> (cmd_be_n == 4'b0000));
  // R6
  sink_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> init_rdy_n);
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && req_ready));
  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (bus_cyc_n && init_rdy_n));
  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);
endmodule

bind burst_rd_init burst_rd_init_chk chk_i (.*);

// File: tb/burst_rd_init_tb_top.sv
module burst_rd_init_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_len_m1 = '0;
  logic        req_io = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        rsp_last;
  logic        done_o;
  logic        err_o;
  logic [31:0] mux_o;
  logic        mux_oe;
  logic [31:0] mux_i = '0;
  logic [3:0]  cmd_be_n;
  logic        bus_cyc_n;
  logic        init_rdy_n;
  logic        tgt_rdy_n = 1'b1;
  logic        tgt_ack_n = 1'b1;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  burst_rd_init dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len_m1(req_len_m1), .req_io(req_io),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .done_o(done_o), .err_o(err_o),
    .mux_o(mux_o), .mux_oe(mux_oe), .mux_i(mux_i), .cmd_be_n(cmd_be_n),
    .bus_cyc_n(bus_cyc_n), .init_rdy_n(init_rdy_n),
    .tgt_rdy_n(tgt_rdy_n), .tgt_ack_n(tgt_ack_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [31:0] a, input int k);
    return a ^ (32'h9E37_79B9 * (k + 1));
  endfunction

  task automatic run(input logic [31:0] addr, input int len, input bit io,
                     input int ack_dly, input int twait, input int bp);
    int  tidx = 0, ridx = 0, dcyc = 0, last_x = -1, n_done = 0;
    bit  exp_err;
    exp_err = (ack_dly == 0) || (ack_dly > 4);

    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_len_m1 = 4'(len - 1); req_io = io;
    tgt_ack_n = 1'b1; tgt_rdy_n = 1'b1; rsp_ready = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R1 idle ready", 32'(req_ready), 32'd1);
    chk(bus_cyc_n && init_rdy_n && !mux_oe, "R1 idle bus", {bus_cyc_n, init_rdy_n, mux_oe}, 3'b110);

    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(mux_oe && !bus_cyc_n && init_rdy_n, "R2 addr strobes", {mux_oe, bus_cyc_n, init_rdy_n}, 3'b101);
    chk(mux_o == addr, "R2 addr value", mux_o, addr);
    chk(cmd_be_n == (io ? 4'b0010 : 4'b0110), "R2 command", 32'(cmd_be_n), io ? 32'h2 : 32'h6);

    while (!(n_done > 0 && !rsp_valid) && dcyc < 400) begin
      @(negedge clk);
      dcyc++;
      tgt_ack_n = !(ack_dly != 0 && dcyc >= ack_dly && n_done == 0);
      tgt_rdy_n = !(!tgt_ack_n && tidx < len && (twait == 0 || (dcyc % twait) != 0));
      mux_i     = word_of(addr, tidx);
      rsp_ready = (bp == 0) || ((dcyc % bp) != 0);
      #1;
      if (dcyc == 1) chk(!mux_oe, "R3 lines released", 32'(mux_oe), 32'd0);
      if (!init_rdy_n) chk(cmd_be_n == 4'b0000, "R3 byte enables", 32'(cmd_be_n), 32'd0);
      if (n_done == 0 && !done_o && tidx < len) begin
        chk(bus_cyc_n == (tidx == len - 1), "R5 framing", 32'(bus_cyc_n), 32'(tidx == len - 1));
        chk(init_rdy_n == (rsp_valid && !rsp_ready), "R6 ready vs sink",
            32'(init_rdy_n), 32'(rsp_valid && !rsp_ready));
      end
      if (done_o) begin
        n_done++;
        chk(err_o == exp_err, "R10 error flag", 32'(err_o), 32'(exp_err));
        chk(bus_cyc_n && init_rdy_n, "R9 bus released", {bus_cyc_n, init_rdy_n}, 2'b11);
        if (exp_err) chk(dcyc == 5, "R10 timeout cycle", dcyc, 32'd5);
        else chk(dcyc == last_x + 1, "R9 done cycle", dcyc, last_x + 1);
      end
      if (rsp_valid && rsp_ready) begin
        chk(rsp_data == word_of(addr, ridx), "R4 word", rsp_data, word_of(addr, ridx));
        chk(rsp_last == (ridx == len - 1), "R8 last flag", 32'(rsp_last), 32'(ridx == len - 1));
        ridx++;
      end
      if (!init_rdy_n && !tgt_rdy_n && !tgt_ack_n) begin
        tidx++;
        last_x = dcyc;
      end
    end
    tgt_ack_n = 1'b1; tgt_rdy_n = 1'b1; rsp_ready = 1'b1;
    chk(n_done == 1, "R9 single done", n_done, 32'd1);
    chk(ridx == (exp_err ? 0 : len), "R11 word count", ridx, exp_err ? 0 : len);
    @(negedge clk);
    #1;
    chk(req_ready && !rsp_valid, "R1 back to idle", {req_ready, rsp_valid}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready && bus_cyc_n && init_rdy_n && !mux_oe && !rsp_valid && !done_o,
        "R1 in reset", {req_ready, bus_cyc_n, init_rdy_n, mux_oe, rsp_valid, done_o}, 6'b111000);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(req_ready && bus_cyc_n && init_rdy_n && !mux_oe && !rsp_valid,
        "R1 after reset", {req_ready, bus_cyc_n, init_rdy_n, mux_oe, rsp_valid}, 5'b11100);

    for (int len = 1; len <= 16; len++) begin
      for (int pat = 0; pat < 4; pat++) begin
        int tw, bp;
        tw = (pat == 1) ? 3 : (pat == 3) ? 2 : 0;
        bp = (pat == 2) ? 2 : (pat == 3) ? 3 : 0;
        run(32'h4000_0000 + 32'(len * 64 + pat * 4), len, len[0], 1 + (len % 4), tw, bp);
      end
    end
    for (int d = 0; d <= 5; d++) begin
      run(32'h0000_8000 + 32'(d * 16), 1, 1'b0, d, 0, 0);
      run(32'h0000_9000 + 32'(d * 16), 4, 1'b1, d, 2, 3);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule